// File: doc/BRIEF.md
# Overflow-Safe 16-bit Ordering Unit

This block is the compare datapath of a small accumulator machine whose branch logic can only test one 16-bit word against zero as a two's complement number. There is no carry or overflow flag. A plain subtract therefore gives the right order only while the true difference fits in 15 bits. The unit closes that gap with a narrowing step on the accumulator high byte. That step runs before the subtract, and it moves the accumulator value close to the operand without changing which of the two is larger. After it, a normal wraparound subtract cannot overflow, and a sign-and-zero test of the result gives the correct order.

A caller loads the first value, applies the signed or unsigned narrowing step with the second value, subtracts the second value, and then reads the six relation flags. Each step is one request on a valid strobe. The request finishes on the next clock edge, and the unit raises a one-cycle done pulse. The work is scheduled by a two-state machine. `ST_IDLE` accepts a request and moves to `ST_DONE` (transition ACCEPT). `ST_DONE` shows done for one cycle and always returns to `ST_IDLE` (transition RETIRE).

Top module: `ordsafe_cmp`

## Requirements
- R1: While rst is high and after it falls, with no request yet, acc reads 0x0000, done is 0, and flags show equal (f_eq=1, f_le=1, f_ge=1, f_lt=0, f_gt=0, f_ne=0).
- R2: A request with in_op=2'b00 (load) makes acc equal in_opnd.
- R3: A request with in_op=2'b01 (subtract) makes acc equal (acc − in_opnd) modulo 2^16.
- R4: A narrowing request (in_op=2'b10 signed, 2'b11 unsigned) leaves acc unchanged when acc bit 15 equals in_opnd bit 15.
- R5: The signed narrowing request (in_op=2'b10) acts when the two bit-15 values differ. If acc bit 15 is 0, the acc high byte becomes (in_opnd[15:8] + 1) mod 256. If acc bit 15 is 1, it becomes (in_opnd[15:8] − 1) mod 256.
- R6: The unsigned narrowing request (in_op=2'b11) acts when the two bit-15 values differ. If acc bit 15 is 0, the acc high byte becomes (in_opnd[15:8] − 1) mod 256. If acc bit 15 is 1, it becomes (in_opnd[15:8] + 1) mod 256.
- R7: A narrowing request never changes acc[7:0].
- R8: The flags depend only on acc. f_lt = acc[15], f_eq = (acc == 0), f_le = f_lt|f_eq, f_gt = !f_le, f_ge = !f_lt, f_ne = !f_eq.
- R9: Load a, signed-narrow with b, then subtract b. Afterwards f_lt, f_eq and f_gt give the signed order of a against b, for all 16-bit a and b.
- R10: The same sequence with the unsigned narrowing step gives the unsigned order of a against b, for all 16-bit a and b.
- R11: A request accepted on one clock edge updates acc on that edge. done is 1 for exactly the following cycle. A valid seen while done is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 load, 01 subtract, 10 signed narrow, 11 unsigned narrow |
| in_opnd | input | 16 | Operand value |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 16 | Accumulator |
| f_lt | output | 1 | Less than zero |
| f_le | output | 1 | Less than or equal to zero |
| f_gt | output | 1 | Greater than zero |
| f_ge | output | 1 | Greater than or equal to zero |
| f_eq | output | 1 | Equal to zero |
| f_ne | output | 1 | Not equal to zero |

## Verification
The assertions assume that in_op and in_opnd are known whenever in_valid is high. They also assume that a request counts as accepted exactly when in_valid is high and done is low, so the checker infers acceptance from the ports alone. The stimulus changes inputs only on falling edges. It holds in_valid for one cycle per request and leaves the unit idle for a cycle before the next one. The one exception is a single directed case that holds in_valid through the done cycle, to show that the extra request is ignored.

// File: rtl/ordsafe_cmp_pkg.sv
package ordsafe_cmp_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_SUB   = 2'b01,
        OP_NAR_S = 2'b10,
        OP_NAR_U = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    typedef struct packed {
        logic lt;
        logic le;
        logic gt;
        logic ge;
        logic eq;
        logic ne;
    } rel_t;
endpackage

// File: rtl/ordsafe_narrow.sv
module ordsafe_narrow #(
    parameter int WIDTH = 16,
    parameter int HB    = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] opnd,
    input  logic             is_signed,
    output logic [WIDTH-1:0] narrowed
);
    localparam int LOW = WIDTH - HB;

    logic [HB-1:0] opnd_hi;
    logic [HB-1:0] hi_inc;
    logic [HB-1:0] hi_dec;
    logic          msb_differ;
    logic          take_inc;

    assign opnd_hi    = opnd[WIDTH-1:LOW];
    assign hi_inc     = opnd_hi + HB'(1);
    assign hi_dec     = opnd_hi - HB'(1);
    assign msb_differ = cur[WIDTH-1] ^ opnd[WIDTH-1];
    // signed: cur non-negative -> sit just above operand; unsigned mirrors it
    assign take_inc   = is_signed ? ~cur[WIDTH-1] : cur[WIDTH-1];

    always_comb begin
        narrowed = cur;
        if (msb_differ) begin
            narrowed[WIDTH-1:LOW] = take_inc ? hi_inc : hi_dec;
        end
    end
endmodule

// File: rtl/ordsafe_flags.sv
module ordsafe_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         value,
    output ordsafe_cmp_pkg::rel_t    rel
);
    logic neg;
    logic zero;

    assign neg  = value[WIDTH-1];
    assign zero = (value == '0);

    always_comb begin
        rel.lt = neg;
        rel.eq = zero;
        rel.le = neg | zero;
        rel.gt = ~(neg | zero);
        rel.ge = ~neg;
        rel.ne = ~zero;
    end
endmodule

// File: rtl/ordsafe_cmp.sv
module ordsafe_cmp #(
    parameter int WIDTH = 16,
    parameter int HB    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [WIDTH-1:0] in_opnd,
    output logic             done,
    output logic [WIDTH-1:0] acc,
    output logic             f_lt,
    output logic             f_le,
    output logic             f_gt,
    output logic             f_ge,
    output logic             f_eq,
    output logic             f_ne
);
    import ordsafe_cmp_pkg::*;

    state_e           state_q, state_d;
    logic [WIDTH-1:0] acc_q, acc_d;
    logic [WIDTH-1:0] narrowed;
    logic [WIDTH-1:0] diff;
    logic             accept;
    op_e              op;
    rel_t             rel;

    assign op     = op_e'(in_op);
    assign accept = in_valid && (state_q == ST_IDLE);
    assign diff   = acc_q - in_opnd;

    ordsafe_narrow #(.WIDTH(WIDTH), .HB(HB)) u_narrow (
        .cur       (acc_q),
        .opnd      (in_opnd),
        .is_signed (op == OP_NAR_S),
        .narrowed  (narrowed)
    );

    ordsafe_flags #(.WIDTH(WIDTH)) u_flags (
        .value (acc_q),
        .rel   (rel)
    );

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_DONE;  // ACCEPT
                    unique case (op)
                        OP_LOAD:  acc_d = in_opnd;
                        OP_SUB:   acc_d = diff;
                        OP_NAR_S,
                        OP_NAR_U: acc_d = narrowed;
                        default:  acc_d = acc_q;
                    endcase
                end
            end
            ST_DONE: state_d = ST_IDLE;  // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // outputs
    always_comb begin
        done = (state_q == ST_DONE);
        acc  = acc_q;
        f_lt = rel.lt;
        f_le = rel.le;
        f_gt = rel.gt;
        f_ge = rel.ge;
        f_eq = rel.eq;
        f_ne = rel.ne;
    end
endmodule

// File: rtl/ordsafe_cmp_chk.sv
module ordsafe_cmp_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [WIDTH-1:0] in_opnd,
    input logic             done,
    input logic [WIDTH-1:0] acc,
    input logic             f_lt,
    input logic             f_le,
    input logic             f_gt,
    input logic             f_ge,
    input logic             f_eq,
    input logic             f_ne
);
    logic take;
    logic take_nar;
    assign take     = in_valid && !done;
    assign take_nar = take && in_op[1];

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc == '0 && !done)); // R1
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == 2'b00) |=> acc == $past(in_opnd)); // R2
    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == 2'b01) |=> acc == WIDTH'($past(acc) - $past(in_opnd))); // R3
    AST_SAME_MSB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (take_nar && (acc[WIDTH-1] == in_opnd[WIDTH-1])) |=> $stable(acc)); // R4
    AST_LOW_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
        take_nar |=> acc[7:0] == $past(acc[7:0])); // R7
    AST_REL_PARTITION: assert property (@(posedge clk) disable iff (rst)
        $countones({f_lt, f_eq, f_gt}) == 1); // R8
    AST_REL_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (f_ge != f_lt) && (f_ne != f_eq) && (f_le != f_gt)); // R8
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        take |=> done); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(acc)); // R11
endmodule

bind ordsafe_cmp ordsafe_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_opnd(in_opnd),
    .done(done), .acc(acc), .f_lt(f_lt), .f_le(f_le), .f_gt(f_gt),
    .f_ge(f_ge), .f_eq(f_eq), .f_ne(f_ne)
);

// File: tb/ordsafe_cmp_bench.sv
module ordsafe_cmp_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [15:0] in_opnd = 16'h0000;
    logic        done;
    logic [15:0] acc;
    logic        f_lt, f_le, f_gt, f_ge, f_eq, f_ne;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'h7FFE, 16'h7FFF,
        16'h8000, 16'h8001, 16'hFF00, 16'hFFFE, 16'hFFFF, 16'h1234
    };

    always #4 clk = ~clk;  // 125 MHz

    ordsafe_cmp u_ordsafe_cmp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_opnd(in_opnd),
        .done(done), .acc(acc), .f_lt(f_lt), .f_le(f_le), .f_gt(f_gt),
        .f_ge(f_ge), .f_eq(f_eq), .f_ne(f_ne)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // one request; returns with done sampled in its cycle and unit idle again
    task automatic issue(input logic [1:0] op, input logic [15:0] v, output logic seen_done);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_opnd = v;
        @(negedge clk);
        in_valid = 1'b0;
        seen_done = done;
        @(negedge clk);
    endtask

    task automatic order_run(input logic [15:0] a, input logic [15:0] b, input bit sgn);
        logic d;
        logic exp_lt, exp_gt;
        string req;
        issue(2'b00, a, d);
        issue(sgn ? 2'b10 : 2'b11, b, d);
        issue(2'b01, b, d);
        exp_lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
        exp_gt = sgn ? ($signed(a) > $signed(b)) : (a > b);
        req = sgn ? "R9" : "R10";
        check(req, {a, b, 1'b0, f_lt, f_eq, f_gt}, {a, b, 1'b0, exp_lt, a == b, exp_gt});
        check("R8", {f_le, f_ge, f_ne}, {~f_gt, ~f_lt, ~f_eq});
    endtask

    task automatic nar_case(input string req, input logic [1:0] op,
                            input logic [15:0] a, input logic [15:0] b, input logic [15:0] exp);
        logic d;
        issue(2'b00, a, d);
        issue(op, b, d);
        check(req, acc, exp);
        check("R7", acc[7:0], a[7:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic d;
        repeat (3) @(negedge clk);
        check("R1", {done, acc, f_lt, f_le, f_gt, f_ge, f_eq, f_ne},
                    {1'b0, 16'h0000, 6'b010110});
        rst = 1'b0;
        @(negedge clk);
        check("R1", {done, acc, f_eq}, {1'b0, 16'h0000, 1'b1});

        // table walk: every pair, both orderings
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < NV; j++) begin
                order_run(VEC[i], VEC[j], 1'b1);
                order_run(VEC[i], VEC[j], 1'b0);
            end
        end

        // R2 load and R11 done timing
        issue(2'b00, 16'hA5C3, d);
        check("R11", d, 1'b1);
        check("R2", acc, 16'hA5C3);
        check("R11", done, 1'b0);
        // R3 subtract with wrap
        issue(2'b00, 16'h0003, d);
        issue(2'b01, 16'h0005, d);
        check("R3", acc, 16'hFFFE);
        issue(2'b01, 16'h7FFF, d);
        check("R3", acc, 16'h7FFF);
        // R4 same top bit
        nar_case("R4", 2'b10, 16'h1234, 16'h7000, 16'h1234);
        nar_case("R4", 2'b11, 16'hC0DE, 16'h8001, 16'hC0DE);
        // R5 signed narrowing
        nar_case("R5", 2'b10, 16'h1234, 16'h9876, 16'h9934);
        nar_case("R5", 2'b10, 16'h8456, 16'h7F00, 16'h7E56);
        nar_case("R5", 2'b10, 16'h8011, 16'h0000, 16'hFF11);
        nar_case("R5", 2'b10, 16'h0022, 16'hFF00, 16'h0022);
        // R6 unsigned narrowing
        nar_case("R6", 2'b11, 16'h1234, 16'h9876, 16'h9734);
        nar_case("R6", 2'b11, 16'h8456, 16'h7F00, 16'h8056);
        nar_case("R6", 2'b11, 16'h0011, 16'h8000, 16'h7F11);
        nar_case("R6", 2'b11, 16'hF0AA, 16'h7F00, 16'h80AA);

        // R11: valid held through done cycle is ignored
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b00; in_opnd = 16'hAAAA;
        @(negedge clk);
        check("R11", done, 1'b1);
        in_opnd = 16'h1234;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", {done, acc}, {1'b0, 16'hAAAA});

        // R1: reset mid-run clears
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", {done, acc, f_eq}, {1'b0, 16'h0000, 1'b1});

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule